// File: doc/BRIEF.md
# Binary BCH Error-Locator Solver

This block solves the key equation for a binary BCH code with correcting power T over GF(2^SYM_W). A syndrome calculator supplies all 2T syndromes as one parallel word together with a one-cycle start strobe. The block runs an inversionless Berlekamp iteration and returns the coefficients of the error-locator polynomial, its degree, and a one-cycle done flag. A Chien search downstream can then use these outputs directly.

The update work is spread over a row of T+1 identical processing elements. Element i holds locator coefficient i and auxiliary coefficient i. It takes its neighbours' values and forms one new coefficient from two field products and one field sum. For binary codes every second Berlekamp step is skipped, so exactly T rounds are run. Each round takes two cycles: the first registers the discrepancy and the second updates the whole row. Field multipliers are combinational shift-and-reduce networks built from the FIELD_POLY parameter.

Top module: `bch_locator`

## Requirements
- R1: While reset is asserted and after it is released, busy, done, every locator coefficient and the degree read zero until the first start.
- R2: A start seen while idle captures syn_in and raises busy from the next cycle. Syndrome S_j (j = 1..2T) sits at syn_in[(j-1)*SYM_W +: SYM_W]. Field elements use the polynomial basis of FIELD_POLY, so x^4+x+1 is 5'h13 and alpha = 4'h2.
- R3: done is high for exactly one cycle. It rises on the 2T-th rising edge after the edge that sampled start, and busy is low while done is high.
- R4: If the syndromes come from at most T errors, loc_deg equals the number of errors. The locator then vanishes at alpha^(-p) exactly for each error position p and at no other power of alpha.
- R5: All-zero syndromes give loc_deg = 0 and the locator 1 + 0x + ... (coefficient 0 equal to 1, all others 0).
- R6: A start raised while busy is ignored: the run neither restarts nor changes its result or its done timing.
- R7: After done, loc_out and loc_deg hold their values until the next accepted start, whatever syn_in does.
- R8: Locator coefficient i sits at loc_out[i*SYM_W +: SYM_W], and coefficient 0 is nonzero whenever done is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released on the clock |
| start_i | input | 1 | Begin a solve using syn_in |
| syn_in | input | 2*T_CORR*SYM_W | Syndromes S_1..S_2T, S_1 in the low bits |
| busy_o | output | 1 | Solve in progress |
| done_o | output | 1 | One-cycle completion strobe |
| loc_out | output | (T_CORR+1)*SYM_W | Locator coefficients, degree 0 in the low bits |
| loc_deg | output | $clog2(2*T_CORR+2)+1 | Locator degree |

## Verification
The bench aims at the auxiliary-polynomial replacement rule by feeding one, two and three errors at random positions, including the first and last positions of the code. If the rule compares degrees off by one, the degree overshoots or the roots move off the injected positions. All-zero syndromes check that a run with no discrepancy leaves the locator exactly 1; a design that rescaled or shifted on a zero discrepancy would fail here. A second start injected mid-run, and syn_in changed after completion, expose a design that restarts while busy or lets the syndrome port leak into held results. Either mistake shows up as a moved done edge or a changed locator.

// File: rtl/bch_locator_pkg.sv
package bch_locator_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_DISC = 2'd1,
    ST_UPD  = 2'd2
  } solve_state_t;
endpackage

// File: rtl/gf_mult.sv
// Combinational GF(2^SYM_W) multiplier, polynomial basis, shift-and-reduce.
module gf_mult #(
  parameter int          SYM_W      = 4,
  parameter logic [31:0] FIELD_POLY = 32'h13
) (
  input  logic [SYM_W-1:0] a_i,
  input  logic [SYM_W-1:0] b_i,
  output logic [SYM_W-1:0] p_o
);
  localparam logic [SYM_W-1:0] RED = FIELD_POLY[SYM_W-1:0];

  always_comb begin
    logic [SYM_W-1:0] acc;
    logic [SYM_W-1:0] sh;
    acc = '0;
    sh  = a_i;
    for (int k = 0; k < SYM_W; k++) begin
      if (b_i[k]) acc = acc ^ sh;
      sh = {sh[SYM_W-2:0], 1'b0} ^ (sh[SYM_W-1] ? RED : '0);
    end
    p_o = acc;
  end
endmodule

// File: rtl/bch_disc.sv
// Discrepancy of round rnd: sum over i of lambda_i * S_(2*rnd+1-i).
module bch_disc #(
  parameter int          SYM_W      = 4,
  parameter logic [31:0] FIELD_POLY = 32'h13,
  parameter int          T_CORR     = 3,
  parameter int          RND_W      = 3
) (
  input  logic [(T_CORR+1)*SYM_W-1:0] lam_flat_i,
  input  logic [2*T_CORR*SYM_W-1:0]   syn_flat_i,
  input  logic [RND_W-1:0]            rnd_i,
  output logic [SYM_W-1:0]            delta_o
);
  localparam int NCOEF = T_CORR + 1;

  logic [SYM_W-1:0] prod [NCOEF];

  for (genvar gi = 0; gi < NCOEF; gi++) begin : g_term
    logic [SYM_W-1:0] s_sel;
    always_comb begin
      int base;
      base  = 2 * int'(rnd_i) - gi;
      s_sel = '0;
      if (base >= 0 && base < 2 * T_CORR) s_sel = syn_flat_i[base*SYM_W +: SYM_W];
    end
    gf_mult #(.SYM_W(SYM_W), .FIELD_POLY(FIELD_POLY)) u_mul (
      .a_i(lam_flat_i[gi*SYM_W +: SYM_W]),
      .b_i(s_sel),
      .p_o(prod[gi])
    );
  end

  always_comb begin
    delta_o = '0;
    for (int i = 0; i < NCOEF; i++) delta_o = delta_o ^ prod[i];
  end
endmodule

// File: rtl/bch_pe.sv
// One coefficient slice: locator and auxiliary registers with their update.
module bch_pe #(
  parameter int          SYM_W      = 4,
  parameter logic [31:0] FIELD_POLY = 32'h13,
  parameter bit          IS_LOW     = 1'b0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             init_i,
  input  logic             upd_i,
  input  logic             replace_i,
  input  logic [SYM_W-1:0] gamma_i,
  input  logic [SYM_W-1:0] delta_i,
  input  logic [SYM_W-1:0] lam_m1_i,
  input  logic [SYM_W-1:0] aux_m1_i,
  input  logic [SYM_W-1:0] aux_m2_i,
  output logic [SYM_W-1:0] lam_o,
  output logic [SYM_W-1:0] aux_o
);
  localparam logic [SYM_W-1:0] SEED = IS_LOW ? SYM_W'(1) : '0;

  logic [SYM_W-1:0] g_lam, d_aux, lam_d, aux_d;
  logic             en;

  gf_mult #(.SYM_W(SYM_W), .FIELD_POLY(FIELD_POLY)) u_mg (
    .a_i(gamma_i), .b_i(lam_o), .p_o(g_lam));
  gf_mult #(.SYM_W(SYM_W), .FIELD_POLY(FIELD_POLY)) u_md (
    .a_i(delta_i), .b_i(aux_m1_i), .p_o(d_aux));

  always_comb begin
    en    = init_i | upd_i;
    lam_d = init_i ? SEED : (g_lam ^ d_aux);
    aux_d = init_i ? SEED : (replace_i ? lam_m1_i : aux_m2_i);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lam_o <= '0;
      aux_o <= '0;
    end else if (en) begin
      lam_o <= lam_d;
      aux_o <= aux_d;
    end
  end

  // R4
  aux_shift_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_i && !init_i && !replace_i) |=> (aux_o == $past(aux_m2_i)));
endmodule

// File: rtl/bch_locator.sv
module bch_locator #(
  parameter int          SYM_W      = 4,
  parameter logic [31:0] FIELD_POLY = 32'h13,
  parameter int          T_CORR     = 3,
  localparam int         DEG_W      = $clog2(2*T_CORR+2) + 1
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        start_i,
  input  logic [2*T_CORR*SYM_W-1:0]   syn_in,
  output logic                        busy_o,
  output logic                        done_o,
  output logic [(T_CORR+1)*SYM_W-1:0] loc_out,
  output logic [DEG_W-1:0]            loc_deg
);
  import bch_locator_pkg::*;

  localparam int NCOEF = T_CORR + 1;
  localparam int RND_W = $clog2(T_CORR) + 1;
  localparam logic [RND_W-1:0] LAST_RND = RND_W'(T_CORR - 1);

  logic [1:0]  rst_sync;
  logic        rst_core;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_core = rst_sync[1];

  solve_state_t state_q, state_d;
  logic [RND_W-1:0]          rnd_q, rnd_d;
  logic [SYM_W-1:0]          delta_q, gamma_q, gamma_d, delta_c;
  logic [DEG_W-1:0]          len_q, len_d, blen_q, blen_d;
  logic [2*T_CORR*SYM_W-1:0] syn_q;
  logic                      done_q, done_d;
  logic                      init, upd, replace, syn_en, delta_en, ctl_en;
  logic [SYM_W-1:0]          lam [NCOEF];
  logic [SYM_W-1:0]          aux [NCOEF];
  logic [NCOEF*SYM_W-1:0]    lam_flat;

  always_comb begin
    init     = (state_q == ST_IDLE) && start_i;
    upd      = (state_q == ST_UPD);
    replace  = (delta_q != '0) && ((blen_q + DEG_W'(1)) > len_q);
    syn_en   = init;
    delta_en = (state_q == ST_DISC);
    ctl_en   = init | upd;
    state_d  = state_q;
    rnd_d    = rnd_q;
    gamma_d  = gamma_q;
    len_d    = len_q;
    blen_d   = blen_q;
    done_d   = 1'b0;
    case (state_q)
      ST_IDLE: if (start_i) begin
        state_d = ST_DISC;
        rnd_d   = '0;
        gamma_d = SYM_W'(1);
        len_d   = '0;
        blen_d  = '0;
      end
      ST_DISC: state_d = ST_UPD;
      ST_UPD: begin
        if (replace) begin
          gamma_d = delta_q;
          len_d   = blen_q + DEG_W'(1);
          blen_d  = len_q + DEG_W'(1);
        end else begin
          blen_d  = blen_q + DEG_W'(2);
        end
        if (rnd_q == LAST_RND) begin
          state_d = ST_IDLE;
          done_d  = 1'b1;
        end else begin
          state_d = ST_DISC;
          rnd_d   = rnd_q + RND_W'(1);
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_core) begin
    if (!rst_core) begin
      state_q <= ST_IDLE;
      done_q  <= 1'b0;
      rnd_q   <= '0;
      gamma_q <= '0;
      len_q   <= '0;
      blen_q  <= '0;
      delta_q <= '0;
      syn_q   <= '0;
    end else begin
      state_q <= state_d;
      done_q  <= done_d;
      if (ctl_en) begin
        rnd_q   <= rnd_d;
        gamma_q <= gamma_d;
        len_q   <= len_d;
        blen_q  <= blen_d;
      end
      if (delta_en) delta_q <= delta_c;
      if (syn_en)   syn_q   <= syn_in;
    end
  end

  for (genvar gi = 0; gi < NCOEF; gi++) begin : g_pe
    logic [SYM_W-1:0] l_m1, a_m1, a_m2;
    if (gi == 0) begin : g_n0
      assign l_m1 = '0;
      assign a_m1 = '0;
    end else begin : g_n1
      assign l_m1 = lam[gi-1];
      assign a_m1 = aux[gi-1];
    end
    if (gi < 2) begin : g_s0
      assign a_m2 = '0;
    end else begin : g_s2
      assign a_m2 = aux[gi-2];
    end
    bch_pe #(.SYM_W(SYM_W), .FIELD_POLY(FIELD_POLY), .IS_LOW(gi == 0)) u_pe (
      .clk(clk), .rst_n(rst_core), .init_i(init), .upd_i(upd),
      .replace_i(replace), .gamma_i(gamma_q), .delta_i(delta_q),
      .lam_m1_i(l_m1), .aux_m1_i(a_m1), .aux_m2_i(a_m2),
      .lam_o(lam[gi]), .aux_o(aux[gi]));
    assign lam_flat[gi*SYM_W +: SYM_W] = lam[gi];
  end

  bch_disc #(.SYM_W(SYM_W), .FIELD_POLY(FIELD_POLY), .T_CORR(T_CORR),
             .RND_W(RND_W)) u_disc (
    .lam_flat_i(lam_flat), .syn_flat_i(syn_q), .rnd_i(rnd_q),
    .delta_o(delta_c));

  assign busy_o  = (state_q != ST_IDLE);
  assign done_o  = done_q;
  assign loc_out = lam_flat;
  assign loc_deg = len_q;

  // R3
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_core)
    done_q |=> !done_q);
  // R3
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_core)
    done_q |-> !busy_o);
  // R8
  lead_nz_chk: assert property (@(posedge clk) disable iff (!rst_core)
    done_q |-> (lam[0] != '0));
  // R7
  hold_chk: assert property (@(posedge clk) disable iff (!rst_core)
    (!busy_o && !start_i) |=> ($stable(loc_out) && $stable(loc_deg)));
  // R6
  busy_start_chk: assert property (@(posedge clk) disable iff (!rst_core)
    (state_q == ST_DISC && start_i) |=> (state_q == ST_UPD));
  // R4
  len_grow_chk: assert property (@(posedge clk) disable iff (!rst_core)
    upd |=> (len_q >= $past(len_q)));
endmodule

// File: tb/bch_locator_tb.sv
module bch_locator_tb;
  localparam int SYM_W = 4;
  localparam int T_CORR = 3;
  localparam int NLEN = 15;
  localparam int DEG_W = $clog2(2*T_CORR+2) + 1;
  localparam int SYNW = 2*T_CORR*SYM_W;
  localparam int LOCW = (T_CORR+1)*SYM_W;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [SYNW-1:0] syn = '0;
  logic busy, done;
  logic [LOCW-1:0] loc;
  logic [DEG_W-1:0] deg;

  int n_chk = 0;
  int n_fail = 0;
  int gf_exp [NLEN];
  int gf_log [16];
  int last_cnt;

  always #5 clk = ~clk;

  bch_locator u_dut (
    .clk(clk), .rst_n(rst_n), .start_i(start), .syn_in(syn),
    .busy_o(busy), .done_o(done), .loc_out(loc), .loc_deg(deg));

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic int gmul(input int a, input int b);
    if (a == 0 || b == 0) return 0;
    return gf_exp[(gf_log[a] + gf_log[b]) % NLEN];
  endfunction

  function automatic int coef(input int i);
    return int'(loc[i*SYM_W +: SYM_W]);
  endfunction

  function automatic int eval_at(input int p);
    int acc = 0;
    int x = (NLEN - p) % NLEN;
    for (int i = 0; i <= T_CORR; i++)
      acc ^= gmul(coef(i), gf_exp[(i * x) % NLEN]);
    return acc;
  endfunction

  function automatic logic [SYNW-1:0] make_syn(input int n, input int p0,
                                               input int p1, input int p2);
    logic [SYNW-1:0] s = '0;
    int pos [3];
    pos[0] = p0; pos[1] = p1; pos[2] = p2;
    for (int j = 1; j <= 2*T_CORR; j++) begin
      int v = 0;
      for (int e = 0; e < n; e++) v ^= gf_exp[(j * pos[e]) % NLEN];
      s[(j-1)*SYM_W +: SYM_W] = SYM_W'(v);
    end
    return s;
  endfunction

  // Runs one solve; optional second start while busy. Samples at negedges.
  task automatic run_solve(input logic [SYNW-1:0] s, input bit extra,
                           input logic [SYNW-1:0] s2);
    int cnt;
    @(negedge clk);
    syn = s; start = 1'b1;
    @(negedge clk);
    start = 1'b0; cnt = 1;
    chk(busy == 1'b1, "R2", "busy after start", int'(busy), 1);
    if (extra) begin
      @(negedge clk); cnt++;
      syn = s2; start = 1'b1;
      @(negedge clk); cnt++;
      start = 1'b0;
    end
    while (!done && cnt < 200) begin
      @(negedge clk); cnt++;
    end
    last_cnt = cnt;
    chk(cnt == 2*T_CORR + 1, "R3", "done latency", cnt, 2*T_CORR + 1);
    chk(busy == 1'b0, "R3", "busy low with done", int'(busy), 0);
    chk(coef(0) != 0, "R8", "coefficient 0 nonzero", coef(0), 1);
    @(negedge clk);
    chk(done == 1'b0, "R3", "done one cycle", int'(done), 0);
  endtask

  task automatic check_roots(input int n, input int p0, input int p1, input int p2);
    int pos [3];
    int roots = 0;
    pos[0] = p0; pos[1] = p1; pos[2] = p2;
    chk(int'(deg) == n, "R4", "degree", int'(deg), n);
    for (int e = 0; e < n; e++)
      chk(eval_at(pos[e]) == 0, "R4", "root at error position", pos[e], 0);
    for (int p = 0; p < NLEN; p++) if (eval_at(p) == 0) roots++;
    chk(roots == n, "R4", "root count", roots, n);
  endtask

  task automatic t_reset();
    chk(busy == 1'b0 && done == 1'b0, "R1", "control idle in reset",
        int'({busy, done}), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(loc == '0, "R1", "locator zero", int'(loc), 0);
    chk(deg == '0, "R1", "degree zero", int'(deg), 0);
    chk(busy == 1'b0, "R1", "busy zero", int'(busy), 0);
  endtask

  task automatic t_zero();
    run_solve('0, 1'b0, '0);
    chk(int'(deg) == 0, "R5", "zero syndrome degree", int'(deg), 0);
    chk(coef(0) == 1, "R5", "coefficient 0", coef(0), 1);
    for (int i = 1; i <= T_CORR; i++)
      chk(coef(i) == 0, "R5", "higher coefficient", coef(i), 0);
  endtask

  task automatic t_errors(input int n, input int p0, input int p1, input int p2);
    run_solve(make_syn(n, p0, p1, p2), 1'b0, '0);
    check_roots(n, p0, p1, p2);
  endtask

  task automatic t_random(input int n);
    int p0, p1, p2;
    p0 = $urandom_range(0, NLEN-1);
    do p1 = $urandom_range(0, NLEN-1); while (p1 == p0);
    do p2 = $urandom_range(0, NLEN-1); while (p2 == p0 || p2 == p1);
    t_errors(n, p0, p1, p2);
  endtask

  task automatic t_busy_start();
    run_solve(make_syn(2, 3, 11, 0), 1'b1, make_syn(1, 7, 0, 0));
    check_roots(2, 3, 11, 0);
    chk(last_cnt == 2*T_CORR + 1, "R6", "no restart", last_cnt, 2*T_CORR + 1);
  endtask

  task automatic t_hold();
    logic [LOCW-1:0] keep_loc;
    logic [DEG_W-1:0] keep_deg;
    run_solve(make_syn(3, 1, 6, 13), 1'b0, '0);
    keep_loc = loc; keep_deg = deg;
    syn = make_syn(1, 9, 0, 0);
    repeat (6) @(negedge clk);
    chk(loc == keep_loc, "R7", "locator held", int'(loc), int'(keep_loc));
    chk(deg == keep_deg, "R7", "degree held", int'(deg), int'(keep_deg));
  endtask

  initial begin
    int v = 1;
    for (int i = 0; i < NLEN; i++) begin
      gf_exp[i] = v;
      gf_log[v] = i;
      v = v << 1;
      if (v & 16) v ^= 'h13;
    end
    gf_log[0] = 0;
    repeat (3) @(negedge clk);
    t_reset();
    t_zero();
    t_errors(1, 0, 0, 0);
    t_errors(1, 14, 0, 0);
    t_errors(2, 0, 14, 0);
    t_errors(3, 0, 7, 14);
    for (int k = 0; k < 6; k++) t_random(1 + (k % 3));
    t_busy_start();
    t_hold();
    t_zero();
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  initial begin
    #100000;
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule